// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Word Receiver

This block turns an asynchronous serial line into parallel words. A one-cycle enable pulse, `os_tick`, arrives sixteen times per bit period, and the block does all of its line sampling on those pulses. Four configuration pins select the word length (5 to 8 data bits), parity on or off, even or odd parity, and a fixed-value parity mode. When a frame starts, the block captures these pins and uses them for that whole frame.

A completed word, with its parity-error and framing-error flags, moves from the shift register into a separate holding register. The block offers the holding register on a valid/ready output stream. `out_valid` is the data-ready indication. A handshake happens at a rising clock edge where `out_valid` and `out_ready` are both high, and it empties the holding register. Back-pressure does not stall the serial line, because nothing can pause the remote transmitter. If a new word completes while the previous one has not been taken, the new word replaces the old one and `out_overrun` marks that at least one word was lost. The host can therefore read one word while the next is still being shifted in.

The serial input is taken to be synchronous to `clk`. The line idles high.

Top module: `serial_word_receiver`

## Requirements
- R1: `wlen_sel` selects the data bits per frame: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8.
- R2: The first data bit after the start bit lands in `out_data[0]`. Later bits fill upward. Bits above the selected word length read 0.
- R3: A frame begins at the first tick on which the line is low after being high on the previous tick. It is accepted only if the line is still low 8 ticks later. If it is not, the event is a glitch: no word is produced and the block waits for the next falling edge.
- R4: Each later bit is sampled 16 ticks after the previous sample. A line that stays low does not start a new frame until it has been seen high. Without a tick, no sampling state advances.
- R5: With `par_en`=1 and `par_stick`=0, a parity bit follows the data bits. `par_even`=1 expects an even number of ones across data and parity, and `par_even`=0 expects an odd number. A mismatch sets `out_perr` with the word. With `par_en`=0 no parity bit is expected and `out_perr` is 0.
- R6: With `par_en`=1 and `par_stick`=1, the expected parity bit is the inverse of `par_even`. Any other received value sets `out_perr`.
- R7: `out_ferr` is set with the word when the stop bit is sampled low.
- R8: `out_valid` rises the cycle after the clock edge at which the stop bit is sampled. While `out_valid` is high and no handshake occurs, `out_data` and its flags hold steady, even while the next frame is being shifted in.
- R9: A handshake with no word completing at that edge clears `out_valid` and `out_overrun`. A word that completes while the holding register is full and not taken at the same edge overwrites it and sets `out_overrun`. A word that completes at the same edge as a handshake loads with `out_overrun` cleared.
- R10: After reset, `out_valid`, `out_overrun`, `out_perr`, `out_ferr` and `out_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idles high |
| wlen_sel | input | 2 | Word length select |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity when 1, odd when 0 |
| par_stick | input | 1 | Parity bit of fixed value |
| out_valid | output | 1 | Holding register full (data ready) |
| out_ready | input | 1 | Host takes the word |
| out_data | output | 8 | Received word, right-justified |
| out_perr | output | 1 | Parity error of the held word |
| out_ferr | output | 1 | Framing error of the held word |
| out_overrun | output | 1 | A word was lost before the held one |

## Verification
The hardest case to reach from the ports is a host read that lands on exactly the clock edge where the next word completes. From the outside, that edge is visible only as a tick partway through the stop bit. The bench runs its own behavioural frame model in step with the design. While a second frame is being received, it watches for the model reaching the final tick count of the stop bit with a tick due. On that cycle, and only that cycle, it raises `out_ready`, so the take and the reload happen at the same edge. Glitch rejection and the rule that a line held low after a framing error starts nothing are reached by driving the line directly instead of sending frames.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int WORD_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // number of data bits for a length select code
  function automatic logic [3:0] word_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  // parity bit the receiver expects for a right-justified word
  function automatic logic want_parity(input logic [WORD_W-1:0] w,
                                       input logic even, input logic stick);
    if (stick) return ~even;
    return even ? ^w : ~^w;
  endfunction
endpackage

// File: rtl/swr_frame_fsm.sv
module swr_frame_fsm
  import swr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        wlen_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              frame_end,
  output logic [WORD_W-1:0] word,
  output logic              perr,
  output logic              ferr
);
  localparam int CNTW = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int IDXW = $clog2(WORD_W);

  rx_state_e         st;
  logic [CNTW-1:0]   cnt;
  logic [IDXW-1:0]   idx;
  logic [WORD_W-1:0] sh;
  logic              pbit;
  logic              line_prev;
  logic [3:0]        l_nbits;
  logic              l_pen, l_even, l_stick;
  logic              at_full, at_half;

  assign at_full   = (cnt == CNTW'(OSR - 1));
  assign at_half   = (cnt == CNTW'(HALF - 1));
  assign frame_end = tick && (st == RX_STOP) && at_full;
  assign word      = sh;
  assign ferr      = ~rxd;
  assign perr      = l_pen && (pbit != want_parity(sh, l_even, l_stick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      sh        <= '0;
      pbit      <= 1'b0;
      line_prev <= 1'b1;
      l_nbits   <= 4'd8;
      l_pen     <= 1'b0;
      l_even    <= 1'b0;
      l_stick   <= 1'b0;
    end else if (tick) begin
      line_prev <= rxd;
      unique case (st)
        RX_IDLE: begin
          if (line_prev && !rxd) begin
            st      <= RX_START;
            cnt     <= '0;
            idx     <= '0;
            sh      <= '0;
            l_nbits <= word_bits(wlen_sel);
            l_pen   <= par_en;
            l_even  <= par_even;
            l_stick <= par_stick;
          end
        end
        RX_START: begin
          if (at_half) begin
            cnt <= '0;
            st  <= rxd ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_full) begin
            cnt     <= '0;
            sh[idx] <= rxd;
            if (idx == IDXW'(l_nbits - 4'd1)) begin
              idx <= '0;
              st  <= l_pen ? RX_PAR : RX_STOP;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_PAR: begin
          if (at_full) begin
            cnt  <= '0;
            pbit <= rxd;
            st   <= RX_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_full) begin
            cnt <= '0;
            st  <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  AST_NO_STEP_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(st) && $stable(cnt) && $stable(idx))); // R4
  AST_GLITCH_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_START && tick && at_half && rxd) |=> (st == RX_IDLE)); // R3
  AST_UPPER_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> ((word >> l_nbits) == '0)); // R2
endmodule

// File: rtl/swr_hold_reg.sv
module swr_hold_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] in_word,
  input  logic          in_perr,
  input  logic          in_ferr,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          ferr,
  output logic          ovr
);
  logic take;
  assign take = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= in_word;
      perr  <= in_perr;
      ferr  <= in_ferr;
      ovr   <= valid && !ready;
    end else if (take) begin
      valid <= 1'b0;
      ovr   <= 1'b0;
    end
  end

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data) && $stable(perr) && $stable(ferr))); // R8
  AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid); // R8
  AST_OVR_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && valid && !ready) |=> ovr); // R9
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> (!valid && !ovr)); // R9
endmodule

// File: rtl/serial_word_receiver.sv
module serial_word_receiver
  import swr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic [1:0]        wlen_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              out_overrun
);
  logic              f_end, f_perr, f_ferr;
  logic [WORD_W-1:0] f_word;

  swr_frame_fsm #(.OSR(OSR)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (os_tick),
    .rxd       (rxd),
    .wlen_sel  (wlen_sel),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .frame_end (f_end),
    .word      (f_word),
    .perr      (f_perr),
    .ferr      (f_ferr)
  );

  swr_hold_reg #(.DW(WORD_W)) i_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (f_end),
    .in_word (f_word),
    .in_perr (f_perr),
    .in_ferr (f_ferr),
    .ready   (out_ready),
    .valid   (out_valid),
    .data    (out_data),
    .perr    (out_perr),
    .ferr    (out_ferr),
    .ovr     (out_overrun)
  );
endmodule

// File: tb/test_serial_word_receiver.sv
module test_serial_word_receiver;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BITCLK     = 16 * TDIV;
  localparam int WDOG       = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] wlen_sel = 2'b11;
  logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid, out_perr, out_ferr, out_overrun;
  logic [7:0] out_data;
  logic       tick;
  int         tcnt = 0;
  int         errors = 0, checks = 0;
  bit         finished = 1'b0;
  bit         cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
  assign tick = (tcnt == TDIV - 1);

  serial_word_receiver i_serial_word_receiver (
    .clk(clk), .rst_n(rst_n), .os_tick(tick), .rxd(rxd), .wlen_sel(wlen_sel),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .out_overrun(out_overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle,1 start,2 data,3 parity,4 stop
  int   m_ph, m_cnt, m_len;
  bit   m_prev, m_pen, m_even, m_stick, m_pbit;
  bit   m_bits[$];
  bit   m_valid, m_perr, m_ferr, m_ovr;
  logic [7:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_prev = 1; m_len = 8;
      m_valid = 0; m_perr = 0; m_ferr = 0; m_ovr = 0; m_data = 0;
      m_bits.delete();
    end else begin
      bit fin, f_fe, f_pe;
      logic [7:0] f_w;
      fin = 0; f_fe = 0; f_pe = 0; f_w = 0;
      if (tick) begin
        if (m_ph == 0) begin
          if (m_prev && !rxd) begin
            m_ph = 1; m_cnt = 0; m_bits.delete();
            m_len = 5 + int'(wlen_sel);
            m_pen = par_en; m_even = par_even; m_stick = par_stick;
          end
        end else if (m_ph == 1) begin
          if (m_cnt == 7) begin m_cnt = 0; m_ph = rxd ? 0 : 2; end
          else m_cnt++;
        end else if (m_cnt == 15) begin
          m_cnt = 0;
          if (m_ph == 2) begin
            m_bits.push_back(rxd);
            if (m_bits.size() == m_len) m_ph = m_pen ? 3 : 4;
          end else if (m_ph == 3) begin
            m_pbit = rxd; m_ph = 4;
          end else begin
            int ones;
            bit expp;
            ones = 0;
            foreach (m_bits[i]) begin f_w[i] = m_bits[i]; ones += int'(m_bits[i]); end
            if (m_stick) expp = !m_even;
            else expp = m_even ? bit'(ones % 2) : bit'(1 - ones % 2);
            f_pe = m_pen && (m_pbit != expp);
            f_fe = !rxd;
            fin = 1; m_ph = 0;
          end
        end else m_cnt++;
        m_prev = rxd;
      end
      if (fin) begin
        m_ovr = m_valid && !out_ready;
        m_valid = 1; m_data = f_w; m_perr = f_pe; m_ferr = f_fe;
      end else if (m_valid && out_ready) begin
        m_valid = 0; m_ovr = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R8 valid vs model", {31'd0, out_valid}, {31'd0, m_valid});
      chk("R2 data vs model", {24'd0, out_data}, {24'd0, m_data});
      chk("R5 perr vs model", {31'd0, out_perr}, {31'd0, m_perr});
      chk("R7 ferr vs model", {31'd0, out_ferr}, {31'd0, m_ferr});
      chk("R9 overrun vs model", {31'd0, out_overrun}, {31'd0, m_ovr});
    end
  end

  function automatic bit par_of(input logic [7:0] d, input int nb, input bit even);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    return even ? bit'(ones % 2) : bit'(1 - ones % 2);
  endfunction

  task automatic set_cfg(input logic [1:0] wl, input bit pe, input bit ev, input bit st);
    wlen_sel = wl; par_en = pe; par_even = ev; par_stick = st;
  endtask

  task automatic hold_line(input bit v, input int bits);
    rxd = v;
    repeat (bits * BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input int nb, input logic [7:0] d, input bit pe, input bit pb,
                            input bit stopv, input bit mid_on, input logic [7:0] mid_exp);
    hold_line(0, 1);
    for (int i = 0; i < nb; i++) begin
      hold_line(d[i], 1);
      if (mid_on && i == 3) chk("R8 held word steady during next frame", {24'd0, out_data}, {24'd0, mid_exp});
    end
    if (pe) hold_line(pb, 1);
    hold_line(stopv, 1);
  endtask

  task automatic take_word();
    out_ready = 1; @(negedge clk); out_ready = 0;
  endtask

  task automatic expect_word(input string tag, input logic [7:0] d, input bit pe, input bit fe);
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " data"}, {24'd0, out_data}, {24'd0, d});
    chk({tag, " perr"}, {31'd0, out_perr}, {31'd0, pe});
    chk({tag, " ferr"}, {31'd0, out_ferr}, {31'd0, fe});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R10 reset data", {24'd0, out_data}, 32'd0);
    chk("R10 reset overrun", {31'd0, out_overrun}, 32'd0);
    rst_n = 1; cmp_on = 1;
    hold_line(1, 2);

    // R1 R2: each word length, right-justified
    set_cfg(2'b11, 0, 0, 0);
    send_frame(8, 8'hA5, 0, 0, 1, 0, 0); hold_line(1, 1);
    expect_word("R1 8-bit", 8'hA5, 0, 0);
    take_word();
    chk("R9 handshake clears valid", {31'd0, out_valid}, 32'd0);
    set_cfg(2'b00, 0, 0, 0);
    send_frame(5, 8'hFF, 0, 0, 1, 0, 0); hold_line(1, 1);
    expect_word("R2 5-bit upper zero", 8'h1F, 0, 0); take_word();
    set_cfg(2'b01, 0, 0, 0);
    send_frame(6, 8'hEC, 0, 0, 1, 0, 0); hold_line(1, 1);
    expect_word("R1 6-bit", 8'h2C, 0, 0); take_word();
    set_cfg(2'b10, 0, 0, 0);
    send_frame(7, 8'h5A, 0, 0, 1, 0, 0); hold_line(1, 1);
    expect_word("R1 7-bit", 8'h5A, 0, 0); take_word();

    // R5 even / odd parity
    set_cfg(2'b10, 1, 1, 0);
    send_frame(7, 8'h53, 1, par_of(8'h53, 7, 1), 1, 0, 0); hold_line(1, 1);
    expect_word("R5 even ok", 8'h53, 0, 0); take_word();
    send_frame(7, 8'h53, 1, !par_of(8'h53, 7, 1), 1, 0, 0); hold_line(1, 1);
    expect_word("R5 even bad", 8'h53, 1, 0); take_word();
    set_cfg(2'b11, 1, 0, 0);
    send_frame(8, 8'h81, 1, par_of(8'h81, 8, 0), 1, 0, 0); hold_line(1, 1);
    expect_word("R5 odd ok", 8'h81, 0, 0); take_word();

    // R6 stick parity
    set_cfg(2'b11, 1, 0, 1);
    send_frame(8, 8'h3C, 1, 1, 1, 0, 0); hold_line(1, 1);
    expect_word("R6 stick one ok", 8'h3C, 0, 0); take_word();
    send_frame(8, 8'h3C, 1, 0, 1, 0, 0); hold_line(1, 1);
    expect_word("R6 stick one bad", 8'h3C, 1, 0); take_word();
    set_cfg(2'b11, 1, 1, 1);
    send_frame(8, 8'h07, 1, 0, 1, 0, 0); hold_line(1, 1);
    expect_word("R6 stick zero ok", 8'h07, 0, 0); take_word();

    // R7 framing error, then R4 line held low starts nothing
    set_cfg(2'b11, 0, 0, 0);
    send_frame(8, 8'h96, 0, 0, 0, 0, 0);
    expect_word("R7 framing", 8'h96, 0, 1); take_word();
    hold_line(0, 20);
    chk("R4 low line starts no frame", {31'd0, out_valid}, 32'd0);
    hold_line(1, 2);

    // R3 glitch
    rxd = 0; repeat (2 * TDIV) @(negedge clk);
    hold_line(1, 15);
    chk("R3 glitch gives no word", {31'd0, out_valid}, 32'd0);

    // R8 R9 overwrite with overrun
    send_frame(8, 8'h11, 0, 0, 1, 0, 0); hold_line(1, 1);
    send_frame(8, 8'h22, 0, 0, 1, 1, 8'h11); hold_line(1, 1);
    expect_word("R9 overwrite", 8'h22, 0, 0);
    chk("R9 overrun set", {31'd0, out_overrun}, 32'd1);
    take_word();
    chk("R9 overrun cleared by read", {31'd0, out_overrun}, 32'd0);

    // R9 read coinciding with completion
    send_frame(8, 8'h33, 0, 0, 1, 0, 0); hold_line(1, 1);
    fork
      send_frame(8, 8'h44, 0, 0, 1, 0, 0);
      begin
        bit hit = 0;
        while (!hit) begin
          @(negedge clk);
          if (m_ph == 4 && m_cnt == 15 && tick) begin
            out_ready = 1; @(negedge clk); out_ready = 0; hit = 1;
          end
        end
      end
    join
    hold_line(1, 1);
    expect_word("R9 coincident read", 8'h44, 0, 0);
    chk("R9 coincident read no overrun", {31'd0, out_overrun}, 32'd0);
    take_word();

    cmp_on = 0; finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule